// File: doc/BRIEF.md
# Interrupt status and mask controller with DMA halt control

The block gathers interrupt requests from a fixed set of source lines and shows them to software through a status word. An enable word selects which of those sources may reach the processor. It drives one level-sensitive interrupt output. The source lines fall into two groups that meet at a parameterised boundary index. Lines below the boundary are ordinary device requests. Their status bits always show the live input level. Lines from the boundary upward are DMA event lines. An event on one of them sets a sticky status bit, and that bit stays set until software clears it.

Every DMA line belongs to one of two classes, set by a parameter mask. An informational event only raises its status bit, and DMA keeps running. An error event also drives the halt output of its own channel. The halt lasts for as long as the sticky bit stays set, so the channel stays stopped until software has acted and cleared the bit. To clear a sticky bit, software writes a word that has a zero in that bit position. Bit positions written as one keep their old value.

The register interface has one address bit. Address 0 selects the status word. Address 1 selects the enable word. Reads are combinational. Writes take effect at the next clock edge.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the enable word reads 0, every DMA status bit reads 0, and `irq_out` and all `dma_halt` bits are 0.
- R2: A write at address 1 loads the enable word, and a read at address 1 returns it. A source whose enable bit is 1 can raise `irq_out`. A source whose enable bit is 0 cannot.
- R3: Status bits below `DMA_BASE` read the live level of `src_in`. A write at address 0 has no effect on them.
- R4: A DMA line that is high at a clock edge sets its status bit (bit position = line index). The bit stays set after the line falls.
- R5: A write at address 0 clears each DMA status bit whose write-data bit is 0. Bits whose write-data bit is 1 keep their value.
- R6: If a DMA event and a clear of the same bit happen at the same edge, the bit ends up set.
- R7: DMA lines whose bit is 1 in `INFO_MASK` never assert `dma_halt`. An informational event that comes again after its bit was cleared sets the bit again.
- R8: For an error-class line, `dma_halt[index - DMA_BASE]` is high exactly while its status bit is set. It rises with the bit and falls when the bit is cleared.
- R9: `irq_out` is a register. After each edge it equals the OR over all lines of (status AND enable), using the status and enable values that hold after that edge. It therefore responds one cycle after a source change, write or clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_LINES | Request lines: ordinary levels below DMA_BASE, DMA events above |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = status word, 1 = enable word |
| bus_wdata | input | NUM_LINES | Write data |
| bus_rdata | output | NUM_LINES | Combinational read data for bus_addr |
| irq_out | output | 1 | Registered, level-sensitive interrupt to the processor |
| dma_halt | output | NUM_LINES-DMA_BASE | Per-channel halt for error-class DMA events |

## Verification
The bench builds the block with its defaults: 32 lines, the DMA boundary at 16, and informational channels 0, 1, 4, 5 and 8 (lines 16, 17, 20, 21, 24). With these values one ordinary line, one informational channel and two neighbouring error channels can all be driven in the same short run. That brings several cases within reach: a clear that collides with an event, a clear that spares a set neighbour, a masked informational event that becomes visible when its enable bit is written, and a reset asserted while halts are active.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

  // Next value of one sticky DMA status bit: a new event wins over a clear.
  function automatic logic sticky_next(input logic cur, input logic ev, input logic clr);
    return ev | (cur & ~clr);
  endfunction

  // Halt output of one DMA channel: only error-class bits stop the channel.
  function automatic logic halt_of(input logic sticky, input logic is_info);
    return sticky & ~is_info;
  endfunction

  // Clear request decoded from a status-word write: a zero bit means clear.
  function automatic logic clear_req(input logic wr_status, input logic wbit);
    return wr_status & ~wbit;
  endfunction

endpackage

// File: rtl/irq_dma_latch.sv
module irq_dma_latch #(
  parameter int        NCH     = 16,
  parameter logic [NCH-1:0] INFO = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ev,
  input  logic [NCH-1:0] clr,
  output logic [NCH-1:0] sticky_q,
  output logic [NCH-1:0] sticky_nxt,
  output logic [NCH-1:0] halt
);
  import irq_stat_pkg::*;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign sticky_nxt[g] = sticky_next(sticky_q[g], ev[g], clr[g]);
    assign halt[g]       = halt_of(sticky_q[g], INFO[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sticky_q[g] <= 1'b0;
      else        sticky_q[g] <= sticky_nxt[g];
    end
  end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] mask_nxt
);
  assign mask_nxt = we ? wdata : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_nxt;
  end
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] stat_nxt,
  input  logic [W-1:0] mask_nxt,
  output logic         any_w,
  output logic         irq_q
);
  assign any_w = |(stat_nxt & mask_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_w;
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int                    NUM_LINES = 32,
  parameter int                    DMA_BASE  = 16,
  parameter logic [NUM_LINES-1:0]  INFO_MASK = 32'h0133_0000
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_LINES-1:0]            src_in,
  input  logic                            bus_wr,
  input  logic                            bus_addr,
  input  logic [NUM_LINES-1:0]            bus_wdata,
  output logic [NUM_LINES-1:0]            bus_rdata,
  output logic                            irq_out,
  output logic [NUM_LINES-DMA_BASE-1:0]   dma_halt
);
  import irq_stat_pkg::*;

  localparam int NUM_DMA = NUM_LINES - DMA_BASE;
  localparam logic [NUM_DMA-1:0] INFO_DMA = INFO_MASK[NUM_LINES-1:DMA_BASE];

  // Named internal events, visible to the bound checker.
  logic                 wr_status_w;
  logic                 wr_mask_w;
  logic [NUM_DMA-1:0]   ev_w;
  logic [NUM_DMA-1:0]   clr_w;
  logic [NUM_DMA-1:0]   dma_stat;
  logic [NUM_DMA-1:0]   dma_stat_nxt;
  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] mask_nxt;
  logic [NUM_LINES-1:0] status_w;
  logic [NUM_LINES-1:0] status_nxt;
  logic                 irq_any_w;

  assign wr_status_w = bus_wr & ~bus_addr;
  assign wr_mask_w   = bus_wr &  bus_addr;
  assign ev_w        = src_in[NUM_LINES-1:DMA_BASE];

  for (genvar g = 0; g < NUM_DMA; g++) begin : g_clr
    assign clr_w[g] = clear_req(wr_status_w, bus_wdata[DMA_BASE+g]);
  end

  irq_dma_latch #(.NCH(NUM_DMA), .INFO(INFO_DMA)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev         (ev_w),
    .clr        (clr_w),
    .sticky_q   (dma_stat),
    .sticky_nxt (dma_stat_nxt),
    .halt       (dma_halt)
  );

  irq_mask_reg #(.W(NUM_LINES)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (wr_mask_w),
    .wdata    (bus_wdata),
    .mask_q   (mask_q),
    .mask_nxt (mask_nxt)
  );

  // Ordinary lines are never stored: the status word shows them live.
  assign status_w   = {dma_stat,     src_in[DMA_BASE-1:0]};
  assign status_nxt = {dma_stat_nxt, src_in[DMA_BASE-1:0]};

  irq_out_stage #(.W(NUM_LINES)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .stat_nxt (status_nxt),
    .mask_nxt (mask_nxt),
    .any_w    (irq_any_w),
    .irq_q    (irq_out)
  );

  assign bus_rdata = bus_addr ? mask_q : status_w;

endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk #(
  parameter int                   NUM_LINES = 32,
  parameter int                   DMA_BASE  = 16,
  parameter logic [NUM_LINES-1:0] INFO_MASK = '0
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          wr_mask_w,
  input logic [NUM_LINES-1:0]          bus_wdata,
  input logic [NUM_LINES-1:0]          mask_q,
  input logic [NUM_LINES-DMA_BASE-1:0] ev_w,
  input logic [NUM_LINES-DMA_BASE-1:0] clr_w,
  input logic [NUM_LINES-DMA_BASE-1:0] dma_stat,
  input logic [NUM_LINES-DMA_BASE-1:0] dma_halt,
  input logic                          irq_any_w,
  input logic                          irq_out
);
  localparam int NUM_DMA = NUM_LINES - DMA_BASE;
  localparam logic [NUM_DMA-1:0] INFO_DMA = INFO_MASK[NUM_LINES-1:DMA_BASE];

  p_mask_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask_w |=> (mask_q == $past(bus_wdata)));

  p_sticky_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((dma_stat & $past(dma_stat & ~clr_w)) == $past(dma_stat & ~clr_w)));

  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((dma_stat & $past(clr_w & ~ev_w)) == '0));

  p_event_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((dma_stat & $past(ev_w)) == $past(ev_w)));

  p_info_no_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((dma_halt & $past(ev_w & INFO_DMA)) == '0));

  p_halt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((dma_halt & $past(dma_halt & ~clr_w)) == $past(dma_halt & ~clr_w)));

  p_irq_reg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == $past(irq_any_w)));

  p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dma_stat & mask_q[NUM_LINES-1:DMA_BASE])) |-> irq_out);

endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(
  .NUM_LINES (NUM_LINES),
  .DMA_BASE  (DMA_BASE),
  .INFO_MASK (INFO_MASK)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_mask_w (wr_mask_w),
  .bus_wdata (bus_wdata),
  .mask_q    (mask_q),
  .ev_w      (ev_w),
  .clr_w     (clr_w),
  .dma_stat  (dma_stat),
  .dma_halt  (dma_halt),
  .irq_any_w (irq_any_w),
  .irq_out   (irq_out)
);

// File: tb/irq_status_ctrl_test.sv
`timescale 1ns/1ps
module irq_status_ctrl_test;
  localparam int NL = 32;
  localparam int DB = 16;
  localparam int ND = NL - DB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] src_in = '0;
  logic          bus_wr = 1'b0;
  logic          bus_addr = 1'b0;
  logic [NL-1:0] bus_wdata = '0;
  logic [NL-1:0] bus_rdata;
  logic          irq_out;
  logic [ND-1:0] dma_halt;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  irq_status_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .dma_halt(dma_halt)
  );

  typedef struct packed {
    logic [31:0] src;
    logic        wr;
    logic        addr;
    logic [31:0] wd;
    logic        e_irq;
    logic [15:0] e_dma;
    logic [15:0] e_halt;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, 16'h0000, 16'h0000}, // R2 enable all
    '{32'h0000_0001, 1'b0, 1'b0, 32'h0,         1'b1, 16'h0000, 16'h0000}, // R3 ordinary high
    '{32'h0000_0000, 1'b0, 1'b0, 32'h0,         1'b0, 16'h0000, 16'h0000}, // R3 ordinary low
    '{32'h0004_0000, 1'b0, 1'b0, 32'h0,         1'b1, 16'h0004, 16'h0004}, // R4 R8 error event
    '{32'h0000_0000, 1'b0, 1'b0, 32'h0,         1'b1, 16'h0004, 16'h0004}, // R4 sticky
    '{32'h0000_0000, 1'b1, 1'b0, 32'hFFFB_FFFF, 1'b0, 16'h0000, 16'h0000}, // R5 R8 clear
    '{32'h0001_0000, 1'b0, 1'b0, 32'h0,         1'b1, 16'h0001, 16'h0000}, // R7 info event
    '{32'h0001_0000, 1'b1, 1'b0, 32'hFFFE_FFFF, 1'b1, 16'h0001, 16'h0000}, // R6 collision
    '{32'h0000_0000, 1'b1, 1'b0, 32'hFFFE_FFFF, 1'b0, 16'h0000, 16'h0000}, // R5 clear
    '{32'h0001_0000, 1'b0, 1'b0, 32'h0,         1'b1, 16'h0001, 16'h0000}, // R7 recurrence
    '{32'h0000_0000, 1'b1, 1'b0, 32'hFFFE_FFFF, 1'b0, 16'h0000, 16'h0000}, // R5 clear
    '{32'h000C_0000, 1'b0, 1'b0, 32'h0,         1'b1, 16'h000C, 16'h000C}, // R8 two errors
    '{32'h0000_0000, 1'b1, 1'b0, 32'hFFFB_FFFF, 1'b1, 16'h0008, 16'h0008}, // R5 ones kept
    '{32'h0000_0008, 1'b1, 1'b0, 32'h0000_0000, 1'b1, 16'h0000, 16'h0000}, // R3 R5 write zeros
    '{32'h0000_0008, 1'b1, 1'b1, 32'h0000_0000, 1'b0, 16'h0000, 16'h0000}, // R2 disable all
    '{32'h0010_0000, 1'b0, 1'b0, 32'h0,         1'b0, 16'h0010, 16'h0000}, // R2 R7 masked info
    '{32'h0000_0000, 1'b1, 1'b1, 32'h0010_0000, 1'b1, 16'h0010, 16'h0000}  // R2 R9 enable it
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    bus_wr = 1'b0; bus_addr = 1'b1; #0.1;
    check({req, " enable word"}, bus_rdata, 32'h0);
    bus_addr = 1'b0; #0.1;
    check({req, " DMA status"}, {16'h0, bus_rdata[31:16]}, 32'h0);
    check({req, " irq_out"}, {31'h0, irq_out}, 32'h0);
    check({req, " dma_halt"}, {16'h0, dma_halt}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL R1 watchdog: done=0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after release");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      src_in = VECS[i].src; bus_wr = VECS[i].wr;
      bus_addr = VECS[i].addr; bus_wdata = VECS[i].wd;
      @(posedge clk);
      #1;
      bus_wr = 1'b0; bus_addr = 1'b0;
      #0.5;
      check($sformatf("R9 v%0d irq_out", i), {31'h0, irq_out}, {31'h0, VECS[i].e_irq});
      check($sformatf("R4 v%0d DMA status", i), {16'h0, bus_rdata[31:16]}, {16'h0, VECS[i].e_dma});
      check($sformatf("R8 v%0d dma_halt", i), {16'h0, dma_halt}, {16'h0, VECS[i].e_halt});
      check($sformatf("R3 v%0d ordinary status", i), {16'h0, bus_rdata[15:0]},
            {16'h0, VECS[i].src[15:0]});
    end

    // R10-style readback of the enable word (part of R2)
    @(negedge clk);
    src_in = '0; bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 32'hA5A5_5A5A;
    @(negedge clk);
    bus_wr = 1'b0; #0.1;
    check("R2 enable readback", bus_rdata, 32'hA5A5_5A5A);

    // R9 latency: enable bit 1 is set, raise ordinary line 1
    bus_addr = 1'b0;
    check("R9 before edge", {31'h0, irq_out}, 32'h0);
    src_in = 32'h0000_0002;
    #1;
    check("R9 no combinational path", {31'h0, irq_out}, 32'h0);
    @(negedge clk);
    check("R9 one cycle later", {31'h0, irq_out}, 32'h1);

    // R1 reset while an error halt is active (line 17 is error? no: use line 22)
    src_in = 32'h0040_0000;
    @(negedge clk);
    src_in = '0;
    check("R8 halt line 22", {16'h0, dma_halt}, 32'h0000_0040);
    rst_n = 1'b0;
    #1;
    check_idle("R1 mid-run reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after second release");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule